// File: doc/BRIEF.md
# Tearing-effect sync trigger

This block decides when a pending frame transfer towards a display with its own frame memory may begin. It watches a single tearing-effect line coming back from the panel. On that one line the panel signals both vertical sync and horizontal sync, and the block tells them apart by how long each pulse stays at its active level, counted in clock ticks. Host logic programs two minimum widths, one for each kind of pulse, and a polarity for each. Once the host raises a transfer request, the block emits a one-cycle start pulse at the right moment.

Three trigger modes are supported. In internal mode the start follows the request at once. In frame mode the start waits for the next vertical sync. In line mode the start waits for vertical sync and then for a programmed number of horizontal pulses. This lets the transfer begin on a chosen scan line, so it stays behind the panel's refresh. A sync error flag reports settings under which the two pulse kinds cannot be told apart reliably. While that flag is set, external triggers are refused.

States of the controller: `ST_IDLE` (nothing pending), `ST_WAIT_VS` (request accepted, waiting for vertical sync), `ST_COUNT_HS` (counting horizontal pulses after vertical sync) and `ST_FIRE` (start pulse cycle). The transitions are:
- IDLE to FIRE on a request in internal mode.
- IDLE to WAIT_VS on a request in an external mode with valid settings.
- WAIT_VS to FIRE on vertical sync in frame mode, or in line mode with a target line of 0.
- WAIT_VS to COUNT_HS on vertical sync in line mode with a nonzero target.
- COUNT_HS to FIRE when the horizontal count reaches the target.
- WAIT_VS or COUNT_HS to IDLE when the settings become invalid.
- FIRE to IDLE always.

Top module: `te_trigger`

## Requirements
- R1: After reset `start_pulse` and `sync_err` are 0 and no transfer is pending.
- R2: With `cfg_mode` = 0 (internal), a request sampled on a rising edge makes `start_pulse` 1 for exactly one cycle, beginning at that same edge.
- R3: Pulse width is the number of rising edges on which `te_in` is sampled at a level. A pulse of at least `cfg_vs_width` ticks at the vertical-sync active level counts as vertical sync. A pulse of at least `cfg_hs_width` ticks, but fewer than `cfg_vs_width` ticks, at the horizontal active level counts as horizontal sync. Shorter pulses are ignored. A pulse is classified when it ends.
- R4: With `cfg_mode` = 1 (frame), a pending transfer starts on the first vertical sync; horizontal pulses are ignored. `start_pulse` rises on the third rising edge counting from the first edge that samples `te_in` inactive.
- R5: With `cfg_mode` = 2 (line), a pending transfer starts when the number of horizontal pulses after vertical sync reaches `cfg_line` (11 bits, 0 to 2047). With `cfg_line` = 0 it starts on the vertical sync itself.
- R6: In line mode, a vertical sync that arrives while horizontal pulses are being counted resets the count to zero.
- R7: Only one transfer can be pending; a request while one is pending has no effect, so at most one start pulse results.
- R8: `cfg_hs_pol` and `cfg_vs_pol` each select the active level of their pulse (1 = active high, 0 = active low).
- R9: `sync_err` is set one cycle after the settings become invalid. The settings are invalid when `cfg_mode` = 3, or when `cfg_mode` is 1 or 2 and any of these holds: `cfg_hs_width` < 2, `cfg_hs_width` = `cfg_vs_width`, or `cfg_vs_width` is below 4 (mode 1) or below 2 (mode 2). Mode 0 never sets it.
- R10: A request made while the settings are invalid is dropped. A pending external transfer is abandoned when the settings become invalid.
- R11: Sync pulses never cause a start pulse unless a transfer is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| te_in | input | 1 | Tearing-effect line from the panel |
| cfg_mode | input | 2 | Trigger mode: 0 internal, 1 frame, 2 line, 3 reserved |
| cfg_hs_pol | input | 1 | Horizontal pulse active level |
| cfg_vs_pol | input | 1 | Vertical pulse active level |
| cfg_hs_width | input | TICK_W | Minimum horizontal pulse width in ticks |
| cfg_vs_width | input | TICK_W | Minimum vertical pulse width in ticks |
| cfg_line | input | LINE_W | Target horizontal pulse count in line mode |
| xfer_req | input | 1 | One-cycle transfer request |
| start_pulse | output | 1 | One-cycle transfer start |
| sync_err | output | 1 | Invalid sync settings flag |

## Verification
Directed pulses placed exactly at, and one tick below, each programmed width show where the classifier draws its boundaries. Sequences that mix vertical sync, horizontal pulses and runt pulses separate frame mode from line mode, and show whether a fresh vertical sync restarts the line count. Randomised widths, gaps, polarities, modes and target lines are compared pulse by pulse against a bench model of the classifier and the pending-request rules. Separate sequences with invalid settings and with repeated requests show that requests are dropped, abandoned or merged as required.

// File: rtl/te_trig_pkg.sv
package te_trig_pkg;

    typedef enum logic [1:0] {
        TRIG_INTERNAL   = 2'd0,
        TRIG_VSYNC      = 2'd1,
        TRIG_VSYNC_LINE = 2'd2,
        TRIG_RESERVED   = 2'd3
    } trig_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_VS  = 2'd1,
        ST_COUNT_HS = 2'd2,
        ST_FIRE     = 2'd3
    } trig_state_e;

    localparam int unsigned HS_MIN_TICKS       = 2;
    localparam int unsigned VS_MIN_TICKS_FRAME = 4;
    localparam int unsigned VS_MIN_TICKS_LINE  = 2;

endpackage

// File: rtl/te_width_meter.sv
module te_width_meter #(
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              level_in,
    input  logic              active_pol,
    output logic [TICK_W-1:0] run_len,
    output logic              run_end
);
    localparam logic [TICK_W-1:0] LEN_MAX = '1;

    logic              act;
    logic              act_d;
    logic [TICK_W-1:0] len_q;

    assign act = (level_in == active_pol);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_d <= 1'b0;
            len_q <= '0;
        end else begin
            act_d <= act;
            if (act) begin
                if (len_q != LEN_MAX) len_q <= len_q + 1'b1;
            end else begin
                len_q <= '0;
            end
        end
    end

    assign run_len = len_q;
    assign run_end = act_d && !act;

    AST_LEN_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (act && len_q == LEN_MAX) |=> (len_q == LEN_MAX)); // R3

endmodule

// File: rtl/te_pulse_classifier.sv
module te_pulse_classifier #(
    parameter int TICK_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              te_in,
    input  logic              hs_pol,
    input  logic              vs_pol,
    input  logic [TICK_W-1:0] hs_width,
    input  logic [TICK_W-1:0] vs_width,
    output logic              hs_evt,
    output logic              vs_evt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   te_s;
    logic [TICK_W-1:0]      hs_len;
    logic [TICK_W-1:0]      vs_len;
    logic                   hs_end;
    logic                   vs_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q[0] <= te_in;
            for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
        end
    end

    assign te_s = sync_q[SYNC_STAGES-1];

    te_width_meter #(.TICK_W(TICK_W)) i_hs_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_in   (te_s),
        .active_pol (hs_pol),
        .run_len    (hs_len),
        .run_end    (hs_end)
    );

    te_width_meter #(.TICK_W(TICK_W)) i_vs_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_in   (te_s),
        .active_pol (vs_pol),
        .run_len    (vs_len),
        .run_end    (vs_end)
    );

    assign vs_evt = vs_end && (vs_len >= vs_width);
    assign hs_evt = hs_end && (hs_len >= hs_width) && (hs_len < vs_width);

    AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_evt && vs_evt)); // R3

endmodule

// File: rtl/te_cfg_check.sv
module te_cfg_check
    import te_trig_pkg::*;
#(
    parameter int TICK_W = 8
) (
    input  logic [1:0]        mode,
    input  logic [TICK_W-1:0] hs_width,
    input  logic [TICK_W-1:0] vs_width,
    output logic              cfg_bad
);
    localparam logic [TICK_W-1:0] HS_MIN       = TICK_W'(HS_MIN_TICKS);
    localparam logic [TICK_W-1:0] VS_MIN_FRAME = TICK_W'(VS_MIN_TICKS_FRAME);
    localparam logic [TICK_W-1:0] VS_MIN_LINE  = TICK_W'(VS_MIN_TICKS_LINE);

    trig_mode_e mode_e;
    logic       common_bad;

    assign mode_e     = trig_mode_e'(mode);
    assign common_bad = (hs_width < HS_MIN) || (hs_width == vs_width);

    always_comb begin
        unique case (mode_e)
            TRIG_INTERNAL:   cfg_bad = 1'b0;
            TRIG_VSYNC:      cfg_bad = common_bad || (vs_width < VS_MIN_FRAME);
            TRIG_VSYNC_LINE: cfg_bad = common_bad || (vs_width < VS_MIN_LINE);
            default:         cfg_bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/te_start_fsm.sv
module te_start_fsm
    import te_trig_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              cfg_bad,
    input  logic              xfer_req,
    input  logic              hs_evt,
    input  logic              vs_evt,
    input  logic [LINE_W-1:0] line_target,
    output logic              start_pulse,
    output logic              sync_err
);
    trig_mode_e        mode_e;
    trig_state_e       state_q;
    trig_state_e       state_d;
    logic [LINE_W-1:0] line_cnt;
    logic [LINE_W-1:0] cnt_inc;

    assign mode_e  = trig_mode_e'(mode);
    assign cnt_inc = line_cnt + 1'b1;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (xfer_req) begin
                    if (mode_e == TRIG_INTERNAL) state_d = ST_FIRE;
                    else if (!cfg_bad)           state_d = ST_WAIT_VS;
                end
            end
            ST_WAIT_VS: begin
                if (mode_e == TRIG_INTERNAL) state_d = ST_FIRE;
                else if (cfg_bad)            state_d = ST_IDLE;
                else if (vs_evt) begin
                    if (mode_e == TRIG_VSYNC || line_target == '0) state_d = ST_FIRE;
                    else                                           state_d = ST_COUNT_HS;
                end
            end
            ST_COUNT_HS: begin
                if (mode_e == TRIG_INTERNAL)                    state_d = ST_FIRE;
                else if (cfg_bad)                               state_d = ST_IDLE;
                else if (hs_evt && (cnt_inc >= line_target))    state_d = ST_FIRE;
            end
            ST_FIRE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  line_cnt <= '0;
        else if (state_q != ST_COUNT_HS || vs_evt)   line_cnt <= '0;
        else if (hs_evt)                             line_cnt <= cnt_inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_err <= 1'b0;
        else        sync_err <= cfg_bad;
    end

    always_comb begin
        start_pulse = (state_q == ST_FIRE);
    end

    AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse); // R2
    AST_INTERNAL_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && xfer_req && mode_e == TRIG_INTERNAL) |=> start_pulse); // R2
    AST_FRAME_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_VS && vs_evt && mode_e == TRIG_VSYNC && !cfg_bad) |=> start_pulse); // R4
    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT_HS && !hs_evt && !vs_evt) |=> $stable(line_cnt)); // R5
    AST_ERR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WAIT_VS || state_q == ST_COUNT_HS) && cfg_bad) |=> (state_q == ST_IDLE)); // R10
    AST_START_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse && $past(state_q) != ST_IDLE)
            |-> $past(vs_evt || hs_evt || mode_e == TRIG_INTERNAL)); // R11

endmodule

// File: rtl/te_trigger.sv
module te_trigger #(
    parameter int TICK_W      = 8,
    parameter int LINE_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              te_in,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_hs_pol,
    input  logic              cfg_vs_pol,
    input  logic [TICK_W-1:0] cfg_hs_width,
    input  logic [TICK_W-1:0] cfg_vs_width,
    input  logic [LINE_W-1:0] cfg_line,
    input  logic              xfer_req,
    output logic              start_pulse,
    output logic              sync_err
);
    logic hs_evt;
    logic vs_evt;
    logic cfg_bad;

    te_pulse_classifier #(.TICK_W(TICK_W), .SYNC_STAGES(SYNC_STAGES)) i_classifier (
        .clk      (clk),
        .rst_n    (rst_n),
        .te_in    (te_in),
        .hs_pol   (cfg_hs_pol),
        .vs_pol   (cfg_vs_pol),
        .hs_width (cfg_hs_width),
        .vs_width (cfg_vs_width),
        .hs_evt   (hs_evt),
        .vs_evt   (vs_evt)
    );

    te_cfg_check #(.TICK_W(TICK_W)) i_cfg_check (
        .mode     (cfg_mode),
        .hs_width (cfg_hs_width),
        .vs_width (cfg_vs_width),
        .cfg_bad  (cfg_bad)
    );

    te_start_fsm #(.LINE_W(LINE_W)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (cfg_mode),
        .cfg_bad     (cfg_bad),
        .xfer_req    (xfer_req),
        .hs_evt      (hs_evt),
        .vs_evt      (vs_evt),
        .line_target (cfg_line),
        .start_pulse (start_pulse),
        .sync_err    (sync_err)
    );

endmodule

// File: tb/test_te_trigger.sv
module test_te_trigger;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        te_in = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic        cfg_hs_pol = 1'b1;
    logic        cfg_vs_pol = 1'b1;
    logic [7:0]  cfg_hs_width = 8'd2;
    logic [7:0]  cfg_vs_width = 8'd5;
    logic [10:0] cfg_line = 11'd0;
    logic        xfer_req = 1'b0;
    logic        start_pulse;
    logic        sync_err;

    int checks = 0;
    int errors = 0;
    int n_start = 0;

    always #4 clk = ~clk;

    te_trigger i_te_trigger (
        .clk(clk), .rst_n(rst_n), .te_in(te_in), .cfg_mode(cfg_mode),
        .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol),
        .cfg_hs_width(cfg_hs_width), .cfg_vs_width(cfg_vs_width),
        .cfg_line(cfg_line), .xfer_req(xfer_req),
        .start_pulse(start_pulse), .sync_err(sync_err)
    );

    always @(posedge clk) begin
        #2;
        if (start_pulse) n_start++;
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        te_in = ~cfg_vs_pol;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        n_start = 0;
    endtask

    task automatic pulse(int w, int g);
        te_in = cfg_vs_pol;
        tick(w);
        te_in = ~cfg_vs_pol;
        tick(g);
    endtask

    task automatic request();
        xfer_req = 1'b1;
        tick(1);
        xfer_req = 1'b0;
    endtask

    function automatic int classify(int w, int hw, int vw);
        if (w >= vw) return 2;
        if (w >= hw) return 1;
        return 0;
    endfunction

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        chk("R1 start after reset", int'(start_pulse), 0);
        chk("R1 sync_err after reset", int'(sync_err), 0);

        // R2 internal trigger latency and width
        request();
        chk("R2 start on request", int'(start_pulse), 1);
        tick(1);
        chk("R2 start one cycle", int'(start_pulse), 0);
        chk("R2 start count", n_start, 1);

        // R11 pulses without a pending transfer
        n_start = 0;
        cfg_mode = 2'd1;
        pulse(6, 5);
        pulse(3, 5);
        pulse(6, 5);
        chk("R11 no request no start", n_start, 0);

        // R4 frame mode: hsync ignored, exact latency
        request();
        pulse(3, 5);
        chk("R4 hsync ignored", n_start, 0);
        te_in = 1'b1;
        tick(6);
        te_in = 1'b0;
        tick(1);
        chk("R4 latency edge 1", int'(start_pulse), 0);
        tick(1);
        chk("R4 latency edge 2", int'(start_pulse), 0);
        tick(1);
        chk("R4 latency edge 3", int'(start_pulse), 1);
        tick(3);
        chk("R4 single start", n_start, 1);

        // R3 and R5 boundaries in line mode
        n_start = 0;
        cfg_mode = 2'd2; cfg_hs_width = 8'd3; cfg_vs_width = 8'd6; cfg_line = 11'd1;
        tick(2);
        request();
        pulse(5, 5);
        chk("R3 width below vs is not vsync", n_start, 0);
        pulse(6, 5);
        chk("R3 vs width exact starts count", n_start, 0);
        pulse(2, 5);
        chk("R3 runt ignored", n_start, 0);
        pulse(3, 5);
        chk("R5 line 1 reached", n_start, 1);

        n_start = 0;
        cfg_line = 11'd0;
        request();
        pulse(6, 5);
        chk("R5 line 0 fires on vsync", n_start, 1);

        // R6 vsync restarts the count
        n_start = 0;
        cfg_line = 11'd3;
        request();
        pulse(6, 5); pulse(3, 5); pulse(4, 5);
        pulse(7, 5);
        pulse(3, 5); pulse(3, 5);
        chk("R6 count restarted", n_start, 0);
        pulse(3, 5);
        chk("R6 fires on third after restart", n_start, 1);

        // R7 second request merges
        n_start = 0;
        cfg_mode = 2'd1; cfg_vs_width = 8'd5;
        request();
        tick(1);
        request();
        pulse(5, 5);
        pulse(5, 5);
        chk("R7 one start for two requests", n_start, 1);

        // R8 active-low pulses
        n_start = 0;
        cfg_hs_pol = 1'b0; cfg_vs_pol = 1'b0;
        te_in = 1'b1;
        tick(4);
        request();
        pulse(3, 5);
        chk("R8 active-low hsync ignored", n_start, 0);
        pulse(5, 5);
        chk("R8 active-low vsync starts", n_start, 1);
        cfg_hs_pol = 1'b1; cfg_vs_pol = 1'b1;
        te_in = 1'b0;
        tick(4);

        // R9 error flag
        cfg_mode = 2'd1; cfg_hs_width = 8'd1; cfg_vs_width = 8'd5;
        tick(1);
        chk("R9 hs width 1", int'(sync_err), 1);
        cfg_hs_width = 8'd2; cfg_vs_width = 8'd3;
        tick(1);
        chk("R9 vs 3 in frame mode", int'(sync_err), 1);
        cfg_mode = 2'd2;
        tick(1);
        chk("R9 vs 3 in line mode ok", int'(sync_err), 0);
        cfg_hs_width = 8'd4; cfg_vs_width = 8'd4;
        tick(1);
        chk("R9 equal widths", int'(sync_err), 1);
        cfg_mode = 2'd3; cfg_hs_width = 8'd2; cfg_vs_width = 8'd5;
        tick(1);
        chk("R9 reserved mode", int'(sync_err), 1);
        cfg_mode = 2'd0; cfg_hs_width = 8'd1;
        tick(1);
        chk("R9 internal never errs", int'(sync_err), 0);

        // R10 dropped and abandoned requests
        n_start = 0;
        cfg_mode = 2'd1; cfg_hs_width = 8'd2; cfg_vs_width = 8'd3;
        tick(1);
        request();
        cfg_vs_width = 8'd5;
        tick(2);
        pulse(6, 5);
        chk("R10 request dropped while invalid", n_start, 0);
        request();
        cfg_hs_width = 8'd1;
        tick(2);
        cfg_hs_width = 8'd2;
        tick(2);
        pulse(6, 5);
        chk("R10 pending abandoned", n_start, 0);

        // Random sequences against the bench model
        for (int it = 0; it < 40; it++) begin
            int hw, vw, md, ln, cnt, exp;
            bit pend, waiting;
            hw = 2 + int'($urandom % 4);
            vw = hw + 1 + int'($urandom % 5);
            md = 1 + int'($urandom % 2);
            ln = int'($urandom % 4);
            if (md == 1 && vw < 4) vw = 4;
            cfg_hs_width = 8'(hw); cfg_vs_width = 8'(vw);
            cfg_mode = 2'(md); cfg_line = 11'(ln);
            cfg_hs_pol = 1'($urandom % 2);
            cfg_vs_pol = cfg_hs_pol;
            do_reset();
            request();
            pend = 1'b1; waiting = 1'b1; cnt = 0; exp = 0;
            for (int p = 0; p < 10; p++) begin
                int w, c;
                w = 1 + int'($urandom % (vw + 2));
                pulse(w, 4 + int'($urandom % 3));
                c = classify(w, hw, vw);
                if (pend) begin
                    if (waiting) begin
                        if (c == 2) begin
                            if (md == 1 || ln == 0) begin exp++; pend = 1'b0; end
                            else begin waiting = 1'b0; cnt = 0; end
                        end
                    end else begin
                        if (c == 2) cnt = 0;
                        else if (c == 1) begin
                            cnt++;
                            if (cnt >= ln) begin exp++; pend = 1'b0; end
                        end
                    end
                end
                chk("R3 R4 R5 random", n_start, exp);
                if (!pend && ($urandom % 3 == 0)) begin
                    request();
                    pend = 1'b1; waiting = 1'b1; cnt = 0;
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule